// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a DMA engine. It turns a byte stream, framed by start and end markers, into frames stored in memory through a ring of two-word buffer descriptors. When a frame begins, it reads the current descriptor and checks whether software still owns it. If the descriptor is free, it packs the bytes into 32-bit words and writes them to the buffer. It then writes back a status word holding the length and the frame-boundary flags, and finally rewrites the address word with its used bit set, which hands the descriptor back to software.

A frame larger than one buffer continues into the next descriptor. Only the first descriptor of a frame carries the start flag, and only the last carries the end flag. After a descriptor whose wrap flag is set, the walk restarts at the ring base address. Software returns a descriptor by clearing its used bit. If the block meets a descriptor that is still marked used, it discards the rest of the frame and pulses a no-buffer flag. Receive is gated by an enable input. While the block is disabled it swallows any input and points its ring pointer back at the base.

Top module: `rxring_writer`

## Requirements
- R1: After reset, memReq, noBuf and frameDone are low, and inReady is high while no frame is in progress.
- R2: The frame data bytes are written in arrival order, little-endian within each 32-bit word, from the buffer address (descriptor word 0 with bits 1:0 cleared). The unused upper bytes of the final word are written as zero.
- R3: Descriptor word 1 is written with the byte count stored in that buffer in bits 13:0, the start-of-frame flag in bit 14, the end-of-frame flag in bit 15, and zero in bits 31:16.
- R4: After its buffer is filled, descriptor word 0 is rewritten with bit 0 (used) set, and with the buffer address in bits 31:2 and the wrap flag in bit 1 unchanged.
- R5: Descriptors are 8 bytes apart. After a descriptor with bit 1 of word 0 set, the next descriptor used is the one at ringBase.
- R6: A frame longer than BUF_BYTES fills BUF_BYTES bytes per descriptor and continues in the next descriptor. The start flag is set only in the first descriptor of the frame, and the end flag only in the last.
- R7: If the fetched descriptor already has its used bit set, the block writes nothing for the rest of the frame, pulses noBuf for one cycle, and does not advance, so the next frame retries that same descriptor.
- R8: While rxEnable is low and no frame is in progress, input bytes are consumed without any memory access. When receive is enabled again, the next frame goes to the descriptor at ringBase.
- R9: frameDone pulses once for each frame that is stored completely, after its last descriptor write-back.
- R10: Once memReq is raised, memReq, memWe, memAddr and memWdata stay unchanged until the cycle in which memAck is seen.
- R11: A byte that arrives while no frame is in progress and that has no start flag is discarded without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable |
| ringBase | input | 32 | Byte address of the first descriptor of the ring |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inReady | output | 1 | Byte is taken at this edge when inValid is high |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write (1) or a read (0) |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| noBuf | output | 1 | One-cycle pulse: a frame was dropped for lack of a free descriptor |
| frameDone | output | 1 | One-cycle pulse: a frame has been stored completely |

## Verification
The assertions assume that memAck is raised only in reply to a pending memReq and lasts a single cycle, and that memRdata is valid in that cycle. The bench memory model follows this rule, with a random delay of zero to two cycles before each acknowledge. The assertions also assume that every frame ends with an end-marked byte before the next start-marked byte arrives. The stimulus tasks always close a frame and insert gaps only between bytes. Software-side changes to the ring are made only while the block is idle, which is how a real driver returns descriptors.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RECV,
    ST_PUTDATA,
    ST_PUTSTAT,
    ST_PUTUSED,
    ST_DROP
  } rxState_t;

  typedef enum logic [1:0] {
    SEL_FETCH,
    SEL_DATA,
    SEL_STAT,
    SEL_USED
  } memSel_t;

  typedef struct packed {
    logic    startFrame;
    logic    resetPtr;
    logic    loadDesc;
    logic    takeByte;
    logic    wordSent;
    logic    advance;
    memSel_t sel;
  } dpCmd_t;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 14;

endpackage

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int BUF_BYTES = 1536,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [WORD_W-1:0] ringBase,
  input  logic [7:0]        inData,
  input  logic              inEof,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              packLast,
  output logic              bufLast,
  output logic              bufFull,
  output logic              frameEnd,
  output logic [CNT_W-1:0]  byteCnt
);

  logic [WORD_W-1:0] curPtr;
  logic              atBase;
  logic [WORD_W-3:0] bufAddr;
  logic              wrapBit;
  logic [WORD_W-1:0] packReg;
  logic [1:0]        packCnt;
  logic [CNT_W-1:0]  dataOff;
  logic              firstDesc;
  logic [WORD_W-1:0] descPtr;
  logic [LEN_W-1:0]  lenField;

  assign descPtr  = atBase ? ringBase : curPtr;
  assign lenField = LEN_W'(byteCnt);
  assign packLast = (packCnt == 2'd3);
  assign bufLast  = (byteCnt == CNT_W'(BUF_BYTES - 1));
  assign bufFull  = (byteCnt == CNT_W'(BUF_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr    <= '0;
      atBase    <= 1'b1;
      bufAddr   <= '0;
      wrapBit   <= 1'b0;
      packReg   <= '0;
      packCnt   <= '0;
      dataOff   <= '0;
      byteCnt   <= '0;
      firstDesc <= 1'b0;
      frameEnd  <= 1'b0;
    end else begin
      if (cmd.resetPtr) atBase <= 1'b1;
      if (cmd.startFrame) begin
        firstDesc <= 1'b1;
        frameEnd  <= 1'b0;
      end
      if (cmd.loadDesc) begin
        bufAddr <= memRdata[WORD_W-1:2];
        wrapBit <= memRdata[1];
        packReg <= '0;
        packCnt <= '0;
        dataOff <= '0;
        byteCnt <= '0;
      end
      if (cmd.takeByte) begin
        packReg[8*packCnt +: 8] <= inData;
        packCnt  <= packCnt + 2'd1;
        byteCnt  <= byteCnt + CNT_W'(1);
        frameEnd <= inEof;
      end
      if (cmd.wordSent) begin
        packReg <= '0;
        packCnt <= '0;
        dataOff <= dataOff + CNT_W'(4);
      end
      if (cmd.advance) begin
        firstDesc <= 1'b0;
        if (wrapBit) begin
          atBase <= 1'b1;
        end else begin
          atBase <= 1'b0;
          curPtr <= descPtr + WORD_W'(8);
        end
      end
    end
  end

  always_comb begin
    memAddr  = descPtr;
    memWdata = '0;
    unique case (cmd.sel)
      SEL_FETCH: memAddr = descPtr;
      SEL_DATA: begin
        memAddr  = {bufAddr, 2'b00} + WORD_W'(dataOff);
        memWdata = packReg;
      end
      SEL_STAT: begin
        memAddr  = descPtr + WORD_W'(4);
        memWdata = {16'b0, frameEnd, firstDesc, lenField};
      end
      SEL_USED: begin
        memAddr  = descPtr;
        memWdata = {bufAddr, wrapBit, 1'b1};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEnable,
  input  logic   inValid,
  input  logic   inSof,
  input  logic   inEof,
  input  logic   memAck,
  input  logic   descUsedIn,
  input  logic   packLast,
  input  logic   bufLast,
  input  logic   bufFull,
  input  logic   frameEnd,
  output dpCmd_t cmd,
  output logic   inReady,
  output logic   memReq,
  output logic   memWe,
  output logic   noBuf,
  output logic   frameDone,
  output logic   ctrlIdle
);

  rxState_t state, nextState;
  logic     dropHit, doneHit;

  assign ctrlIdle = (state == ST_IDLE);

  always_comb begin
    cmd       = '0;
    cmd.sel   = SEL_FETCH;
    nextState = state;
    inReady   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    dropHit   = 1'b0;
    doneHit   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cmd.resetPtr = !rxEnable;
        inReady      = !(rxEnable && inSof);
        if (inValid && rxEnable && inSof) begin
          cmd.startFrame = 1'b1;
          nextState      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq  = 1'b1;
        cmd.sel = SEL_FETCH;
        if (memAck) begin
          if (descUsedIn) begin
            dropHit   = 1'b1;
            nextState = ST_DROP;
          end else begin
            cmd.loadDesc = 1'b1;
            nextState    = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        inReady = 1'b1;
        cmd.sel = SEL_DATA;
        if (inValid) begin
          cmd.takeByte = 1'b1;
          if (inEof || packLast || bufLast) nextState = ST_PUTDATA;
        end
      end
      ST_PUTDATA: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        cmd.sel = SEL_DATA;
        if (memAck) begin
          cmd.wordSent = 1'b1;
          nextState    = (frameEnd || bufFull) ? ST_PUTSTAT : ST_RECV;
        end
      end
      ST_PUTSTAT: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        cmd.sel = SEL_STAT;
        if (memAck) nextState = ST_PUTUSED;
      end
      ST_PUTUSED: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        cmd.sel = SEL_USED;
        if (memAck) begin
          cmd.advance = 1'b1;
          doneHit     = frameEnd;
          nextState   = frameEnd ? ST_IDLE : ST_FETCH;
        end
      end
      ST_DROP: begin
        inReady = 1'b1;
        if (inValid && inEof) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      noBuf     <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      state     <= nextState;
      noBuf     <= dropHit;
      frameDone <= doneHit;
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic [31:0] ringBase,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inSof,
  input  logic        inEof,
  output logic        inReady,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        noBuf,
  output logic        frameDone
);

  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  dpCmd_t           cmd;
  logic             packLast, bufLast, bufFull, frameEnd, ctrlIdle;
  logic [CNT_W-1:0] byteCnt;

  rxring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable),
    .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .memAck(memAck), .descUsedIn(memRdata[0]),
    .packLast(packLast), .bufLast(bufLast), .bufFull(bufFull),
    .frameEnd(frameEnd), .cmd(cmd), .inReady(inReady),
    .memReq(memReq), .memWe(memWe), .noBuf(noBuf),
    .frameDone(frameDone), .ctrlIdle(ctrlIdle)
  );

  rxring_dp #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ringBase(ringBase),
    .inData(inData), .inEof(inEof), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .packLast(packLast), .bufLast(bufLast), .bufFull(bufFull),
    .frameEnd(frameEnd), .byteCnt(byteCnt)
  );

endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int BUF_BYTES = 1536,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxEnable,
  input logic             inReady,
  input logic             memReq,
  input logic             memWe,
  input logic [31:0]      memAddr,
  input logic [31:0]      memWdata,
  input logic             memAck,
  input logic             noBuf,
  input logic             frameDone,
  input logic             ctrlIdle,
  input logic [CNT_W-1:0] byteCnt
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIdle && !rxEnable) |=> !memReq);

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(BUF_BYTES));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(noBuf && frameDone));

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(memAck && memWe));

  // R7
  nobuf_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    noBuf |-> $past(memAck && !memWe));

  // R2
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && memReq));

endmodule

bind rxring_writer rxring_chk #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .inReady(inReady),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .noBuf(noBuf), .frameDone(frameDone),
  .ctrlIdle(ctrlIdle), .byteCnt(byteCnt)
);

// File: tb/tb_rxring_writer.sv
module tb_rxring_writer;

  localparam int BUF   = 16;
  localparam int NDESC = 4;
  localparam logic [31:0] BASE    = 32'h100;
  localparam logic [31:0] BUFBASE = 32'h400;

  logic        clk = 1'b0, rstN = 1'b0, rxEnable = 1'b0;
  logic [31:0] ringBase = BASE;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady, memReq, memWe, noBuf, frameDone;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  logic [31:0] mem [0:1023];
  int wrCount = 0, doneCnt = 0, noBufCnt = 0, dly = 0;
  int nChecks = 0, nFails = 0, expIdx = 0;

  rxring_writer #(.BUF_BYTES(BUF)) dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .ringBase(ringBase),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof),
    .inReady(inReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .noBuf(noBuf), .frameDone(frameDone)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      dly    <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (dly == 0) begin
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[11:2]] <= memWdata;
          wrCount <= wrCount + 1;
        end else begin
          memRdata <= mem[memAddr[11:2]];
        end
        dly <= $urandom_range(2, 0);
      end else begin
        dly <= dly - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (frameDone) doneCnt <= doneCnt + 1;
    if (noBuf) noBufCnt <= noBufCnt + 1;
  end

  function automatic logic [7:0] byteVal(int fid, int i);
    return 8'(fid * 29 + i * 7 + 3);
  endfunction

  function automatic int descA(int idx);
    return int'(BASE) + idx * 8;
  endfunction

  function automatic int bufA(int idx);
    return int'(BUFBASE) + idx * 64;
  endfunction

  function automatic logic [7:0] memByte(int a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic initRing();
    for (int i = 0; i < NDESC; i++) begin
      mem[descA(i) >> 2]       = 32'(bufA(i)) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
      mem[(descA(i) >> 2) + 1] = 32'h0;
      for (int k = 0; k < 16; k++) mem[(bufA(i) >> 2) + k] = 32'hA5A5A5A5;
    end
  endtask

  task automatic setUsed(input int idx, input bit u);
    mem[descA(idx) >> 2][0] = u;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    inValid = 1'b1; inData = d; inSof = s; inEof = e;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic sendFrame(input int fid, input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(3, 0) == 0)) begin
        @(negedge clk);
        inValid = 1'b0;
      end
      sendByte(byteVal(fid, i), i == 0, i == len - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic sendAndWait(input int fid, input int len, input bit gaps);
    int d0, n0, t;
    d0 = doneCnt; n0 = noBufCnt; t = 0;
    sendFrame(fid, len, gaps);
    while (doneCnt == d0 && noBufCnt == n0 && t < 300) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic checkFrame(input int fid, input int len);
    int rem, pos, j, idx, seg;
    logic [31:0] e1, e0;
    bit ok;
    rem = len; pos = 0; j = 0;
    while (rem > 0) begin
      idx = expIdx;
      seg = (rem > BUF) ? BUF : rem;
      e1 = 32'(seg) | ((rem == seg) ? 32'h8000 : 32'h0) | ((j == 0) ? 32'h4000 : 32'h0);
      chk(mem[(descA(idx) >> 2) + 1] == e1, (j == 0) ? "R3 status word" : "R6 continuation status",
          mem[(descA(idx) >> 2) + 1], e1);
      e0 = 32'(bufA(idx)) | ((idx == NDESC - 1) ? 32'h2 : 32'h0) | 32'h1;
      chk(mem[descA(idx) >> 2] == e0, "R4 used bit write-back", mem[descA(idx) >> 2], e0);
      ok = 1'b1;
      for (int k = 0; k < seg; k++)
        if (memByte(bufA(idx) + k) != byteVal(fid, pos + k)) ok = 1'b0;
      for (int k = seg; k < ((seg + 3) / 4) * 4; k++)
        if (memByte(bufA(idx) + k) != 8'h00) ok = 1'b0;
      chk(ok, "R2 buffer data", 32'(ok), 32'h1);
      setUsed(idx, 1'b0);
      expIdx = (idx == NDESC - 1) ? 0 : idx + 1;
      rem -= seg; pos += seg; j++;
    end
  endtask

  task automatic goodFrame(input int fid, input int len, input bit gaps, input string tag);
    int d0;
    d0 = doneCnt;
    sendAndWait(fid, len, gaps);
    chk(doneCnt == d0 + 1, tag, 32'(doneCnt - d0), 32'h1);
    checkFrame(fid, len);
  endtask

  initial begin
    #4000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int w0, d0, n0;
    logic [31:0] saved;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    initRing();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(memReq == 1'b0 && noBuf == 1'b0 && frameDone == 1'b0, "R1 reset outputs",
        {29'b0, memReq, noBuf, frameDone}, 32'h0);
    chk(inReady == 1'b1, "R1 ready when idle", 32'(inReady), 32'h1);

    // R8: disabled receive swallows a frame
    w0 = wrCount; d0 = doneCnt;
    sendAndWait(1, 10, 1'b0);
    chk(wrCount == w0 && doneCnt == d0, "R8 disabled no access", 32'(wrCount - w0), 32'h0);

    rxEnable = 1'b1;
    expIdx = 0;
    goodFrame(2, 5, 1'b0, "R9 done pulse short frame");
    goodFrame(3, 16, 1'b0, "R9 done pulse full buffer");
    goodFrame(4, 40, 1'b0, "R5 R6 spanning wrap frame");
    chk(expIdx == 1, "R5 ring position after wrap", 32'(expIdx), 32'h1);

    // R7: first descriptor still owned by software
    setUsed(1, 1'b1);
    saved = mem[(descA(1) >> 2) + 1];
    w0 = wrCount; d0 = doneCnt; n0 = noBufCnt;
    sendAndWait(5, 7, 1'b0);
    chk(noBufCnt == n0 + 1, "R7 noBuf pulse", 32'(noBufCnt - n0), 32'h1);
    chk(wrCount == w0 && doneCnt == d0, "R7 nothing written", 32'(wrCount - w0), 32'h0);
    chk(mem[(descA(1) >> 2) + 1] == saved, "R7 status untouched", mem[(descA(1) >> 2) + 1], saved);
    setUsed(1, 1'b0);
    goodFrame(6, 3, 1'b0, "R7 retry same descriptor");

    // R7 R6: continuation descriptor still owned
    setUsed(3, 1'b1);
    d0 = doneCnt; n0 = noBufCnt;
    sendAndWait(7, 20, 1'b0);
    chk(noBufCnt == n0 + 1, "R7 continuation noBuf", 32'(noBufCnt - n0), 32'h1);
    chk(doneCnt == d0, "R7 continuation no done", 32'(doneCnt - d0), 32'h0);
    chk(mem[(descA(2) >> 2) + 1] == 32'h4010, "R6 partial frame first status",
        mem[(descA(2) >> 2) + 1], 32'h4010);
    chk(mem[descA(2) >> 2][0] == 1'b1, "R4 partial frame used", 32'(mem[descA(2) >> 2][0]), 32'h1);
    setUsed(2, 1'b0);
    setUsed(3, 1'b0);
    expIdx = 3;

    // R11: stray byte outside a frame
    w0 = wrCount;
    sendByte(8'h77, 1'b0, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    repeat (10) @(posedge clk);
    chk(wrCount == w0, "R11 stray byte ignored", 32'(wrCount - w0), 32'h0);
    goodFrame(8, 6, 1'b0, "R11 frame after stray byte");

    // R8: disable returns pointer to base
    @(negedge clk);
    rxEnable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rxEnable = 1'b1;
    expIdx = 0;
    goodFrame(9, 9, 1'b0, "R8 restart at base");

    for (int f = 0; f < 14; f++) begin
      int len;
      len = $urandom_range(48, 1);
      goodFrame(20 + f, len, 1'b1, "R9 random frame");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule